// File: doc/BRIEF.md
# Embedded-Sync Video Output Generator

This block turns a stream of active pixels into a continuous 10-bit digital video stream. Sync, blanking and field information are carried inside the data as timing reference codes, not on separate pins. A set of static mode inputs defines the raster: active width, horizontal blanking length, active height, and one or two vertical blanking lengths. One input selects progressive or interlaced (two-field) format. Each line is sent as an end-of-active code, the horizontal blanking filler, a start-of-active code, and then the active region.

In the active region of picture lines, the block pulls pixels from a ready/valid stream. If that stream runs dry, the raster pauses. During vertical blanking the active region of a line can carry ancillary words from a second ready/valid stream. This starts at a programmable line, and field 0 of an interlaced frame has its own start line. The block also drives a marker and the current line number for a downstream serializer that inserts line numbers and CRCs.

Top module: `vid_sync_gen`

## Requirements
- R1: Exactly one sample leaves on every clock. A line is laid out as h positions 0..3 end-of-active code, then `cfg_h_blank` filler positions, then 4 positions of start-of-active code, then `cfg_h_active` active positions. The output register puts the sample of each position on `vid_data` one clock after the block is at that position.
- R2: Each timing code is the word sequence 3FFh, 000h, 000h, XYZ. In XYZ, bit 9 = 1, bit 8 = F, bit 7 = V and bit 6 = H (H = 1 for end-of-active, 0 for start-of-active). The protection bits are bit 5 = V^H, bit 4 = F^H, bit 3 = F^V and bit 2 = F^V^H. Bits 1:0 = 0.
- R3: `vid_trs` is high exactly on the cycle whose `vid_data` is the 3FFh word of a timing code.
- R4: A filler stretch alternates 200h and 040h, starting with 200h on its first sample. The filler stretches are the horizontal blanking and the active region of a blanking line that carries no ancillary word.
- R5: `vid_line` gives the line of the sample on `vid_data`. It starts at 1 after reset, counts up by one per line, and wraps to 1 after the total line count.
- R6: Progressive raster: lines 1..vb0 are blanking (V=1) and the next `cfg_v_active` lines are picture, all with F=0. Interlaced raster: after those lines come `cfg_v_blank1` blanking lines and `cfg_v_active` picture lines, all with F=1. The total line count is the sum of the sections in use.
- R7: `pix_ready` is high only in the active region of picture lines. Accepted pixels appear on `vid_data` in the order they were accepted, and no input is taken during blanking.
- R8: If `pix_valid` is low while `pix_ready` is high, the block stalls. It emits 040h and holds its raster position until a pixel arrives.
- R9: Ancillary words are taken (`anc_ready` high) only in the active region of blanking lines whose number is at least the start line. When `anc_valid` is low there, filler is sent instead.
- R10: In interlaced mode the field-0 blanking lines use `cfg_anc_line_f0` as the start line. Field-1 blanking lines, and all lines in progressive mode, use `cfg_anc_line`.
- R11: While reset is held, `vid_data` is 040h, `vid_trs` is 0 and `vid_line` is 1. The first sample after reset is the 3FFh of line 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_interlaced | input | 1 | 1 selects the two-field raster |
| cfg_h_active | input | HW | Active samples per line |
| cfg_h_blank | input | HW | Filler samples between the two timing codes |
| cfg_v_active | input | VW | Picture lines per field |
| cfg_v_blank0 | input | VW | Blanking lines before field 0 picture |
| cfg_v_blank1 | input | VW | Blanking lines before field 1 picture |
| cfg_anc_line | input | VW | Ancillary start line (progressive, field 1) |
| cfg_anc_line_f0 | input | VW | Ancillary start line for interlaced field 0 |
| pix_valid | input | 1 | Pixel word available |
| pix_data | input | DW | Pixel word |
| pix_ready | output | 1 | Block takes a pixel this cycle |
| anc_valid | input | 1 | Ancillary word available |
| anc_data | input | DW | Ancillary word |
| anc_ready | output | 1 | Block takes an ancillary word this cycle |
| vid_data | output | DW | Output video sample |
| vid_trs | output | 1 | Marks the 3FFh word of a timing code |
| vid_line | output | VW | Line number of the sample on vid_data |

## Verification
The assertions assume the mode inputs stay constant between resets. They also assume every length is nonzero, the start lines lie inside the raster, and the total line count fits in VW bits. The bench changes the mode only while reset is asserted and uses small legal rasters of 16-sample lines. It drives `pix_valid` and `anc_valid` with periodic gaps, so that stalls and missing ancillary words both occur.

// File: rtl/vid_sync_gen.sv
module vid_sync_gen #(
  parameter int DW = 10,
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_interlaced,
  input  logic [HW-1:0] cfg_h_active,
  input  logic [HW-1:0] cfg_h_blank,
  input  logic [VW-1:0] cfg_v_active,
  input  logic [VW-1:0] cfg_v_blank0,
  input  logic [VW-1:0] cfg_v_blank1,
  input  logic [VW-1:0] cfg_anc_line,
  input  logic [VW-1:0] cfg_anc_line_f0,
  input  logic          pix_valid,
  input  logic [DW-1:0] pix_data,
  output logic          pix_ready,
  input  logic          anc_valid,
  input  logic [DW-1:0] anc_data,
  output logic          anc_ready,
  output logic [DW-1:0] vid_data,
  output logic          vid_trs,
  output logic [VW-1:0] vid_line
);
  localparam logic [DW-1:0] BLACK  = DW'(10'h040);
  localparam logic [DW-1:0] CHROMA = DW'(10'h200);
  localparam logic [DW-1:0] ONES   = {DW{1'b1}};

  logic [HW:0]   h;
  logic [VW-1:0] line;

  wire [HW:0] sav_at = {1'b0, cfg_h_blank} + (HW+1)'(4);
  wire [HW:0] act_at = sav_at + (HW+1)'(4);
  wire [HW:0] h_last = act_at + {1'b0, cfg_h_active} - (HW+1)'(1);

  wire in_eav = h < (HW+1)'(4);
  wire in_sav = (h >= sav_at) && (h < act_at);
  wire in_act = h >= act_at;
  wire in_trs = in_eav || in_sav;

  wire [VW:0] ln     = {1'b0, line};
  wire [VW:0] a0_end = {1'b0, cfg_v_blank0} + {1'b0, cfg_v_active};
  wire [VW:0] b1_end = a0_end + {1'b0, cfg_v_blank1};
  wire [VW:0] total  = cfg_interlaced ? b1_end + {1'b0, cfg_v_active} : a0_end;

  wire fld = cfg_interlaced && (ln > a0_end);
  wire vbl = (ln <= {1'b0, cfg_v_blank0}) || (fld && ln <= b1_end);
  wire [VW-1:0] anc_first = (cfg_interlaced && !fld) ? cfg_anc_line_f0 : cfg_anc_line;

  assign pix_ready = in_act && !vbl;
  assign anc_ready = in_act && vbl && (line >= anc_first);
  wire stall = pix_ready && !pix_valid;

  wire [1:0] trs_idx = in_eav ? h[1:0] : h[1:0] - sav_at[1:0];
  wire hb = in_eav;
  wire [DW-1:0] xyz = DW'({1'b1, fld, vbl, hb, vbl ^ hb, fld ^ hb, fld ^ vbl, fld ^ vbl ^ hb, 2'b00});
  wire fill_odd = in_act ? (h[0] ^ act_at[0]) : h[0];

  logic [DW-1:0] nxt;
  always_comb begin
    if (in_trs) begin
      case (trs_idx)
        2'd0:    nxt = ONES;
        2'd3:    nxt = xyz;
        default: nxt = '0;
      endcase
    end else if (pix_ready) begin
      nxt = pix_valid ? pix_data : BLACK;
    end else if (anc_ready && anc_valid) begin
      nxt = anc_data;
    end else begin
      nxt = fill_odd ? BLACK : CHROMA;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h        <= '0;
      line     <= VW'(1);
      vid_data <= BLACK;
      vid_trs  <= 1'b0;
      vid_line <= VW'(1);
    end else begin
      vid_data <= nxt;
      vid_trs  <= in_trs && (trs_idx == 2'd0);
      vid_line <= line;
      if (!stall) begin
        if (h >= h_last) begin
          h    <= '0;
          line <= (ln >= total) ? VW'(1) : line + VW'(1);
        end else begin
          h <= h + (HW+1)'(1);
        end
      end
    end
  end

  assert_trs_is_3ff_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vid_trs |-> vid_data == ONES);

  assert_trs_then_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vid_trs |=> (vid_data == '0 && !vid_trs));

  assert_one_taker_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_ready && anc_ready));

  assert_anc_in_vblank_R9: assert property (@(posedge clk) disable iff (!rst_n)
    anc_ready |-> vbl);

  assert_stall_black_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_ready && !pix_valid) |=> (vid_data == BLACK && !vid_trs));

  assert_line_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_line != '0) && ({1'b0, vid_line} <= total));
endmodule

// File: tb/vid_sync_gen_bench.sv
module vid_sync_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 10, HW = 12, VW = 11;

  localparam logic [9:0] LINE1 [16] = '{
    10'h3FF, 10'h000, 10'h000, 10'h2D8, 10'h200, 10'h040, 10'h200, 10'h040,
    10'h3FF, 10'h000, 10'h000, 10'h2AC, 10'h200, 10'h040, 10'h200, 10'h040};

  logic clk = 0, rst_n = 0;
  logic cfg_interlaced = 0;
  logic [HW-1:0] cfg_h_active = 4, cfg_h_blank = 4;
  logic [VW-1:0] cfg_v_active = 2, cfg_v_blank0 = 2, cfg_v_blank1 = 1;
  logic [VW-1:0] cfg_anc_line = 2, cfg_anc_line_f0 = 2;
  logic pix_valid = 0, anc_valid = 0;
  logic [DW-1:0] pix_data = 0, anc_data = 0;
  logic pix_ready, anc_ready, vid_trs;
  logic [DW-1:0] vid_data;
  logic [VW-1:0] vid_line;

  int errors = 0, checks = 0;
  int bh, bl, pcnt, acnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_sync_gen #(.DW(DW), .HW(HW), .VW(VW)) u_vid_sync_gen (
    .clk, .rst_n, .cfg_interlaced, .cfg_h_active, .cfg_h_blank, .cfg_v_active,
    .cfg_v_blank0, .cfg_v_blank1, .cfg_anc_line, .cfg_anc_line_f0,
    .pix_valid, .pix_data, .pix_ready, .anc_valid, .anc_data, .anc_ready,
    .vid_data, .vid_trs, .vid_line);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (h=%0d line=%0d)", tag, act, exp, bh, bl);
    end
  endtask

  function automatic logic [9:0] xyz(bit f, bit v, bit hh);
    return {1'b1, f, v, hh, v ^ hh, f ^ hh, f ^ v, f ^ v ^ hh, 2'b00};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; pix_valid = 0; anc_valid = 0;
    repeat (2) @(negedge clk);
    chk("R11 data", vid_data, 10'h040);
    chk("R11 trs", vid_trs, 0);
    chk("R11 line", vid_line, 1);
    rst_n = 1;
    bh = 0; bl = 1; pcnt = 10'h100; acnt = 10'h300;
  endtask

  task automatic run(int n, bit gaps);
    for (int c = 0; c < n; c++) begin
      int hb, aw, sav, act, last, a0, b1, tot, st, e;
      bit il, fld, vb, eav, sv, ac, er, aok, et, pv, av;
      string tag;
      il = cfg_interlaced; hb = cfg_h_blank; aw = cfg_h_active;
      pv = gaps ? (c % 5 != 3) : 1'b1;
      av = (c % 3 != 1);
      pix_valid = pv; anc_valid = av; pix_data = pcnt; anc_data = acnt;
      #1;
      sav = hb + 4; act = hb + 8; last = hb + aw + 7;
      a0 = cfg_v_blank0 + cfg_v_active; b1 = a0 + cfg_v_blank1;
      tot = il ? b1 + cfg_v_active : a0;
      fld = il && bl > a0;
      vb = (bl <= cfg_v_blank0) || (fld && bl <= b1);
      st = (il && !fld) ? cfg_anc_line_f0 : cfg_anc_line;
      eav = bh < 4; sv = bh >= sav && bh < act; ac = bh >= act;
      er = ac && !vb; aok = ac && vb && bl >= st;
      et = 0;
      if (eav || sv) begin
        int k;
        k = eav ? bh : bh - sav;
        e = (k == 0) ? 10'h3FF : (k == 3) ? xyz(fld, vb, eav) : 0;
        et = (k == 0);
        tag = (k == 3) ? "R2/R6 xyz" : "R2 trs word";
      end else if (er) begin
        e = pv ? pcnt : 10'h040;
        tag = pv ? "R7 pixel" : "R8 stall";
      end else if (aok && av) begin
        e = acnt;
        tag = il ? "R10 anc word" : "R9 anc word";
      end else begin
        e = (((ac ? bh - act : bh - 4) % 2) == 1) ? 10'h040 : 10'h200;
        tag = "R4 filler";
      end
      chk("R7 pix_ready", pix_ready, er);
      chk(il ? "R10 anc_ready" : "R9 anc_ready", anc_ready, aok);
      @(posedge clk);
      @(negedge clk);
      chk(tag, vid_data, e);
      chk("R3 vid_trs", vid_trs, et);
      chk("R5 vid_line", vid_line, bl);
      if (er && pv) pcnt = (pcnt + 1) % 1024;
      if (aok && av) acnt = (acnt + 1) % 1024;
      if (!(er && !pv)) begin
        if (bh == last) begin
          bh = 0;
          bl = (bl >= tot) ? 1 : bl + 1;
        end else bh++;
      end
    end
  endtask

  initial begin
    do_reset();
    for (int i = 0; i < 16; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R1 line1 sample", vid_data, LINE1[i]);
      chk("R3 line1 trs", vid_trs, (i == 0 || i == 8));
      chk("R5 line1 num", vid_line, 1);
    end
    do_reset();
    run(160, 0);
    do_reset();
    run(200, 1);
    cfg_interlaced = 1; cfg_anc_line = 5; cfg_anc_line_f0 = 2;
    do_reset();
    run(260, 1);
    cfg_anc_line_f0 = 1;
    do_reset();
    run(240, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule